// File: doc/BRIEF.md
# Jitter Attenuator Reference Selector

This block picks the timing reference that the receive-side digitally controlled oscillator follows. It can pick one of four recovered line clocks, an external SYNC clock, or none. With no reference the oscillator runs free at its centre frequency. The choice depends on a master/slave mode bit, a loss-of-signal flag and an auto-switch disable bit. It also depends on whether SYNC is toggling, which the block measures itself against its own sampling clock.

All reference inputs are treated as asynchronous. Each one passes through a two-flop synchronizer and a rising-edge detector. The selected reference leaves the block as a stream of single-cycle pulses in the sampling-clock domain, together with a registered one-hot code that names the source.

The pulse output is a timing stream, not a data stream. It carries no valid/ready pair and cannot be back-pressured: the receiver must accept a pulse in every cycle in which it appears. All control and status pins are plain levels. Control inputs are sampled on each rising edge of `clk`.

Top module: `jitter_ref_selector`

## Requirements
- R1: While `rst_n` is low, and after it is released with SYNC absent and master mode selected, `ref_sel` is 6'b000001 (free-run/centered), `ref_pulse` is 0 and `sync_present` is 0.
- R2: `ref_sel` encodes the source one-hot: bit 0 means free-run, bit 1 means SYNC, and bit 2+n means line clock n. In slave mode without loss of signal, the edge after any sample shows bit 2+`line_sel`.
- R3: In slave mode with loss of signal and `auto_sw_dis` clear, the choice is the same as in master mode: SYNC if `sync_present` is 1, free-run otherwise.
- R4: While loss of signal is flagged and `auto_sw_dis` is 1, the selected line clock is kept in either mode. In master mode without loss of signal, `auto_sw_dis` has no effect on the choice.
- R5: In master mode without loss of signal and with `sync_present` at 0, free-run is selected and `ref_pulse` stays 0.
- R6: In master mode without loss of signal and with `sync_present` at 1, SYNC is selected.
- R7: `sync_present` rises once `MIN_EDGES` rising edges of SYNC are counted within one detection window. The window is `WIN_LO` sampling cycles when `freq_sel` is 0 (1.544 MHz expected) and `WIN_HI` when it is 1 (2.048 MHz expected).
- R8: `sync_present` falls after a full detection window passes with no rising edge on SYNC.
- R9: Each rising edge of the selected reference gives exactly one `ref_pulse` cycle. The pulse appears three sampling edges after the input change is first sampled.
- R10: In the cycle in which `ref_sel` takes a new value, `ref_pulse` is 0.
- R11: `ref_sel` always has exactly one bit set and changes only on a rising edge of `clk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_master | input | 1 | 1 = master mode, 0 = slave mode |
| los | input | 1 | Loss of signal on the receive line |
| auto_sw_dis | input | 1 | Disables the automatic fallback away from the line clock |
| line_sel | input | 2 | Index of the line clock to track |
| freq_sel | input | 1 | Expected SYNC rate: 0 = 1.544 MHz, 1 = 2.048 MHz |
| line_clk | input | 4 | Recovered line clocks (asynchronous) |
| sync_clk | input | 1 | External SYNC clock (asynchronous; static when unused) |
| ref_sel | output | 6 | One-hot selected source |
| ref_pulse | output | 1 | One pulse per rising edge of the selected reference |
| sync_present | output | 1 | SYNC detected as toggling |

## Verification
The bench builds the block with `WIN_LO`=40, `WIN_HI`=24 and `MIN_EDGES`=4. With these values, SYNC is detected as present and as absent within a few dozen cycles, so every transition of the selection table can be reached in a short run, including the fallbacks that depend on SYNC. Because the two windows differ, the bench can also show that `freq_sel` selects the window. The bench toggles SYNC at a different rate in each window, so that presence is detected close to the window edge.

// File: rtl/refsel_pkg.sv
package refsel_pkg;
  localparam int NUM_LINES = 4;
  localparam int LSEL_W    = $clog2(NUM_LINES);
  localparam int SEL_W     = NUM_LINES + 2;
  localparam int SRC_W     = NUM_LINES + 1;

  localparam logic [SEL_W-1:0] CODE_FREE = SEL_W'(1);
  localparam logic [SEL_W-1:0] CODE_SYNC = SEL_W'(2);

  typedef enum logic [1:0] {
    SRC_FREE = 2'd0,
    SRC_SYNC = 2'd1,
    SRC_LINE = 2'd2
  } src_e;

  function automatic logic [SEL_W-1:0] src_code(src_e src, logic [LSEL_W-1:0] lsel);
    logic [SEL_W-1:0] code;
    case (src)
      SRC_SYNC: code = CODE_SYNC;
      SRC_LINE: code = SEL_W'(4) << lsel;
      default:  code = CODE_FREE;
    endcase
    return code;
  endfunction
endpackage

// File: rtl/refsel_sync_edge.sv
module refsel_sync_edge #(
  parameter int WIDTH  = 5,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] rise
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain <= '0;
      end else begin
        chain <= {chain[STAGES-1:0], async_in[b]};
      end
    end
    assign rise[b] = chain[STAGES-1] & ~chain[STAGES];
  end
endmodule

// File: rtl/refsel_presence.sv
module refsel_presence #(
  parameter int WIN_LO    = 256,
  parameter int WIN_HI    = 256,
  parameter int MIN_EDGES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic freq_sel,
  input  logic edge_in,
  output logic present
);
  localparam int WIN_MAX = (WIN_LO > WIN_HI) ? WIN_LO : WIN_HI;
  localparam int CW      = $clog2(WIN_MAX + 1);
  localparam int EW      = $clog2(MIN_EDGES + 1);
  localparam int EW1     = EW + 1;

  logic [CW-1:0]  win_last;
  logic [CW-1:0]  wcnt;
  logic [CW-1:0]  icnt;
  logic [EW-1:0]  ecnt;
  logic [EW1-1:0] esum;
  logic           hit;
  logic           wrap;
  logic           quiet;

  assign win_last = freq_sel ? CW'(WIN_HI - 1) : CW'(WIN_LO - 1);
  assign esum     = {1'b0, ecnt} + EW1'(edge_in);
  assign hit      = esum >= EW1'(MIN_EDGES);
  assign wrap     = wcnt >= win_last;
  assign quiet    = (icnt >= win_last) && !edge_in;

  // Window of counted edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wcnt <= '0;
      ecnt <= '0;
    end else if (wrap) begin
      wcnt <= '0;
      ecnt <= EW'(edge_in);
    end else begin
      wcnt <= wcnt + 1'b1;
      ecnt <= hit ? EW'(MIN_EDGES) : esum[EW-1:0];
    end
  end

  // Cycles since the last edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      icnt <= '0;
    end else if (edge_in) begin
      icnt <= '0;
    end else if (icnt < win_last) begin
      icnt <= icnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      present <= 1'b0;
    end else if (hit) begin
      present <= 1'b1;
    end else if (quiet) begin
      present <= 1'b0;
    end
  end
endmodule

// File: rtl/refsel_select.sv
module refsel_select
  import refsel_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 mode_master,
  input  logic                 los,
  input  logic                 auto_sw_dis,
  input  logic [LSEL_W-1:0]    line_sel,
  input  logic                 sync_present,
  input  logic                 sync_rise,
  input  logic [NUM_LINES-1:0] line_rise,
  output logic [SEL_W-1:0]     ref_sel,
  output logic                 ref_pulse
);
  src_e             src_next;
  logic [SEL_W-1:0] code_next;
  logic             keep_line;
  logic             cand_rise;

  assign keep_line = (!mode_master && !los) || (los && auto_sw_dis);

  always_comb begin
    if (keep_line) begin
      src_next = SRC_LINE;
    end else if (sync_present) begin
      src_next = SRC_SYNC;
    end else begin
      src_next = SRC_FREE;
    end
  end

  assign code_next = src_code(src_next, line_sel);
  assign cand_rise = |(ref_sel & {line_rise, sync_rise, 1'b0});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_sel   <= CODE_FREE;
      ref_pulse <= 1'b0;
    end else begin
      ref_sel   <= code_next;
      ref_pulse <= (code_next == ref_sel) && cand_rise;
    end
  end
endmodule

// File: rtl/jitter_ref_selector.sv
module jitter_ref_selector
  import refsel_pkg::*;
#(
  parameter int WIN_LO    = 256,
  parameter int WIN_HI    = 256,
  parameter int MIN_EDGES = 4,
  parameter int SYNC_FF   = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 mode_master,
  input  logic                 los,
  input  logic                 auto_sw_dis,
  input  logic [LSEL_W-1:0]    line_sel,
  input  logic                 freq_sel,
  input  logic [NUM_LINES-1:0] line_clk,
  input  logic                 sync_clk,
  output logic [SEL_W-1:0]     ref_sel,
  output logic                 ref_pulse,
  output logic                 sync_present
);
  logic [SRC_W-1:0] rises;

  refsel_sync_edge #(
    .WIDTH  (SRC_W),
    .STAGES (SYNC_FF)
  ) u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in ({line_clk, sync_clk}),
    .rise     (rises)
  );

  refsel_presence #(
    .WIN_LO    (WIN_LO),
    .WIN_HI    (WIN_HI),
    .MIN_EDGES (MIN_EDGES)
  ) u_pres (
    .clk      (clk),
    .rst_n    (rst_n),
    .freq_sel (freq_sel),
    .edge_in  (rises[0]),
    .present  (sync_present)
  );

  refsel_select u_sel (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_master  (mode_master),
    .los          (los),
    .auto_sw_dis  (auto_sw_dis),
    .line_sel     (line_sel),
    .sync_present (sync_present),
    .sync_rise    (rises[0]),
    .line_rise    (rises[SRC_W-1:1]),
    .ref_sel      (ref_sel),
    .ref_pulse    (ref_pulse)
  );
endmodule

// File: rtl/jitter_ref_selector_chk.sv
module jitter_ref_selector_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       mode_master,
  input logic       los,
  input logic       auto_sw_dis,
  input logic [1:0] line_sel,
  input logic [5:0] ref_sel,
  input logic       ref_pulse,
  input logic       sync_present
);
  // R11
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(ref_sel) == 1);

  // R2
  slave_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_master && !los) |=> (ref_sel == (6'b000100 << $past(line_sel))));

  // R4
  dis_keep_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (los && auto_sw_dis) |=> (ref_sel == (6'b000100 << $past(line_sel))));

  // R5
  master_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_master && !los && !sync_present) |=> (ref_sel == 6'b000001));

  // R6
  master_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_master && !los && sync_present) |=> (ref_sel == 6'b000010));

  // R10
  switch_mute_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ref_sel) |-> !ref_pulse);

  // R5
  free_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_sel[0] |-> !ref_pulse);
endmodule

bind jitter_ref_selector jitter_ref_selector_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .mode_master  (mode_master),
  .los          (los),
  .auto_sw_dis  (auto_sw_dis),
  .line_sel     (line_sel),
  .ref_sel      (ref_sel),
  .ref_pulse    (ref_pulse),
  .sync_present (sync_present)
);

// File: tb/tb_jitter_ref_selector.sv
module tb_jitter_ref_selector;
  localparam int WLO = 40;
  localparam int WHI = 24;
  localparam int MINE = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_master = 1'b1;
  logic       los = 1'b0;
  logic       auto_sw_dis = 1'b0;
  logic [1:0] line_sel = 2'd0;
  logic       freq_sel = 1'b0;
  logic [3:0] line_clk = 4'd0;
  logic       sync_clk = 1'b1;
  logic [5:0] ref_sel;
  logic       ref_pulse;
  logic       sync_present;

  int checks = 0;
  int errors = 0;
  string phase = "R1";

  always #4 clk = ~clk;

  jitter_ref_selector #(.WIN_LO(WLO), .WIN_HI(WHI), .MIN_EDGES(MINE)) dut (
    .clk(clk), .rst_n(rst_n), .mode_master(mode_master), .los(los),
    .auto_sw_dis(auto_sw_dis), .line_sel(line_sel), .freq_sel(freq_sel),
    .line_clk(line_clk), .sync_clk(sync_clk), .ref_sel(ref_sel),
    .ref_pulse(ref_pulse), .sync_present(sync_present));

  // Behavioural reference model
  int m_sel, m_pulse, m_pres, wc, ec, ic;
  int hs[3];
  int hl[4][3];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sel = 0; m_pulse = 0; m_pres = 0; wc = 0; ec = 0; ic = 0;
      for (int k = 0; k < 3; k++) begin
        hs[k] = 0;
        for (int i = 0; i < 4; i++) hl[i][k] = 0;
      end
    end else begin
      int rs, win, tgt, newp, rr;
      int rl[4];
      bit hit;
      rs = (hs[1] == 1 && hs[2] == 0) ? 1 : 0;
      for (int i = 0; i < 4; i++) rl[i] = (hl[i][1] == 1 && hl[i][2] == 0) ? 1 : 0;
      win = freq_sel ? WHI : WLO;
      hit = (ec + rs) >= MINE;
      newp = hit ? 1 : ((ic >= win - 1 && rs == 0) ? 0 : m_pres);
      if (wc >= win - 1) begin
        wc = 0; ec = rs;
      end else begin
        wc = wc + 1; ec = hit ? MINE : ec + rs;
      end
      ic = rs ? 0 : ((ic >= win - 1) ? ic : ic + 1);
      if ((!mode_master && !los) || (los && auto_sw_dis)) tgt = 2 + int'(line_sel);
      else tgt = m_pres ? 1 : 0;
      if (m_sel == 0) rr = 0;
      else if (m_sel == 1) rr = rs;
      else rr = rl[m_sel - 2];
      m_pulse = (tgt == m_sel) ? rr : 0;
      m_sel = tgt;
      m_pres = newp;
      hs[2] = hs[1]; hs[1] = hs[0]; hs[0] = int'(sync_clk);
      for (int i = 0; i < 4; i++) begin
        hl[i][2] = hl[i][1]; hl[i][1] = hl[i][0]; hl[i][0] = int'(line_clk[i]);
      end
    end
  end

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  logic [5:0] prev_sel = 6'b000001;
  int cyc = 0;
  bit sync_en = 1'b0;
  int sync_half = 4;

  task automatic run(int n);
    for (int j = 0; j < n; j++) begin
      @(negedge clk);
      check(phase, "ref_sel", int'(ref_sel), 1 << m_sel);
      check(phase, "ref_pulse", int'(ref_pulse), m_pulse);
      check(phase, "sync_present", int'(sync_present), m_pres);
      check("R11", "onehot", $countones(ref_sel), 1);
      if (ref_sel != prev_sel) check("R10", "mute", int'(ref_pulse), 0);
      prev_sel = ref_sel;
      cyc++;
      for (int i = 0; i < 4; i++) if (cyc % (3 + i) == 0) line_clk[i] = ~line_clk[i];
      if (sync_en && (cyc % sync_half == 0)) sync_clk = ~sync_clk;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "reset ref_sel", int'(ref_sel), 1);
    check("R1", "reset ref_pulse", int'(ref_pulse), 0);
    check("R1", "reset sync_present", int'(sync_present), 0);
    rst_n = 1'b1;
    phase = "R1 R5";
    run(20);
    check("R1", "free after reset", int'(ref_sel), 1);

    phase = "R2 R9";
    mode_master = 1'b0;
    for (int s = 0; s < 4; s++) begin
      line_sel = 2'(s);
      run(50);
      check("R2", "line code", int'(ref_sel), 4 << s);
    end

    phase = "R6 R7";
    mode_master = 1'b1; sync_en = 1'b1; sync_half = 4; freq_sel = 1'b0;
    run(120);
    check("R7", "present lo window", int'(sync_present), 1);
    check("R6", "sync chosen", int'(ref_sel), 2);

    phase = "R8 R5";
    sync_en = 1'b0; sync_clk = 1'b1;
    run(100);
    check("R8", "absent", int'(sync_present), 0);
    check("R5", "free", int'(ref_sel), 1);

    phase = "R7 R6";
    freq_sel = 1'b1; sync_en = 1'b1; sync_half = 2;
    run(80);
    check("R7", "present hi window", int'(sync_present), 1);

    phase = "R3";
    mode_master = 1'b0; los = 1'b1; auto_sw_dis = 1'b0; line_sel = 2'd1;
    run(40);
    check("R3", "slave los sync", int'(ref_sel), 2);
    sync_en = 1'b0; sync_clk = 1'b1;
    run(80);
    check("R3", "slave los free", int'(ref_sel), 1);

    phase = "R4";
    auto_sw_dis = 1'b1; line_sel = 2'd3;
    run(40);
    check("R4", "slave los dis", int'(ref_sel), 32);
    mode_master = 1'b1; line_sel = 2'd2;
    run(40);
    check("R4", "master los dis", int'(ref_sel), 16);
    los = 1'b0;
    run(40);
    check("R4", "master dis ignored free", int'(ref_sel), 1);
    sync_en = 1'b1; freq_sel = 1'b0; sync_half = 3;
    run(100);
    check("R4", "master dis ignored sync", int'(ref_sel), 2);

    phase = "R10 R2";
    mode_master = 1'b0;
    for (int s = 0; s < 8; s++) begin
      line_sel = 2'(s % 4);
      run(7);
    end
    run(20);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule